// File: doc/BRIEF.md
# Collective Reduction and Multicast Engine

This block sits beside a switch crossbar and carries out collective reductions for many independent groups of endpoint ports. Each group has its own member set, operator and integer format. Every member port sends one partial value tagged with the group number. The engine folds each value into the group's accumulator as it arrives. Once every member has contributed, the engine sends the single result back to every member port. Each endpoint therefore sends once and receives once per step, instead of trading a partial with every other member.

Contributions enter on per-port valid/ready streams. A round-robin arbiter accepts at most one of them per cycle. A configuration write sets a group's member mask, operator and signed/unsigned format, and clears any arrivals that group has collected. Results leave on per-port valid/ready streams. Each port has its own output register, so a stalled port holds back only the group whose result it has not yet taken. A repeated contribution from a port, or a contribution from a port outside the group, is consumed, discarded and reported on an error pulse.

Top module: `crx_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `err_flag` are 0. With no input valid, `in_ready` is 0.
- R2: In a cycle with `cfg_we` high, no contribution is accepted. The write stores the mask, operator and format for `cfg_grp` and clears that group's arrivals, so values sent before the write do not count.
- R3: At most one `in_ready` bit is high per cycle, and only on a port whose `in_valid` is high. Requesting ports are served in round-robin order.
- R4: A result is released only when the arrival set equals the member mask. It reaches each member port exactly once and never reaches a port outside the mask.
- R5: Operator codes on `cfg_op`: 0 add (wraps modulo 2^W), 1 minimum, 2 maximum, 3 bitwise AND, 4 bitwise OR, 5 bitwise XOR.
- R6: With `cfg_sgn`=1, minimum and maximum compare the values as two's complement numbers. With 0, they compare them as unsigned numbers.
- R7: The accumulator takes the first arriving value as it is, so a group with one member returns that member's value for every operator.
- R8: A second contribution from the same port before the group completes, or a contribution from a non-member, is accepted and discarded. `err_flag` is high for the one cycle after the accepting edge, and the result does not change.
- R9: An output with `out_ready` low keeps `out_valid` high and `out_data` stable. A group cannot take new contributions until every member has accepted its result, while other groups carry on.
- R10: `out_valid` rises on the second clock edge after the edge that accepts the completing contribution: low just after that edge, high after the next one.
- R11: Groups run independently. A completion in one group leaves the arrivals of other groups untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_grp | input | GW | Group being configured |
| cfg_mask | input | NPORT | Member port mask |
| cfg_op | input | 3 | Operator code |
| cfg_sgn | input | 1 | 1 = signed compare, 0 = unsigned |
| in_valid | input | NPORT | Contribution valid per port |
| in_ready | output | NPORT | Contribution accepted per port |
| in_grp | input | NPORT*GW | Group tag per port |
| in_data | input | NPORT*W | Contribution value per port |
| out_valid | output | NPORT | Result valid per port |
| out_ready | input | NPORT | Result taken per port |
| out_grp | output | NPORT*GW | Group of the result per port |
| out_data | output | NPORT*W | Result value per port |
| err_flag | output | 1 | Dropped-contribution pulse |

## Verification
`in_ready` follows `in_valid` within the same cycle. The bench therefore sets inputs on the falling edge and reads `in_ready` a short delay later, before the accepting rising edge. `err_flag` is due one edge after acceptance and is read on the falling edge right after it. `out_valid` is due one edge later still (R10). The bench checks that it is low at the first falling edge after the completing acceptance and high at the next one. Results are gathered from handshakes sampled between edges. They are compared, a few cycles after completion, with values the bench computes arithmetically from the operator, the format and the randomly ordered contributions.

// File: rtl/crx_pkg.sv
package crx_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MIN = 3'd1,
    OP_MAX = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5
  } red_op_e;
endpackage

// File: rtl/crx_alu.sv
module crx_alu
  import crx_pkg::*;
#(
  parameter int W = 16
) (
  input  red_op_e        op,
  input  logic           sgn,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  logic lt;

  always_comb begin
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    case (op)
      OP_ADD:  y = a + b;
      OP_MIN:  y = lt ? a : b;
      OP_MAX:  y = lt ? b : a;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/crx_rr_arb.sv
module crx_rr_arb #(
  parameter int N  = 8,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [PW-1:0] gnt_idx,
  output logic          any
);
  logic [PW-1:0] ptr_q;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      int j;
      j = int'(ptr_q) + i;
      if (j >= N) j = j - N;
      if (!any && req[j]) begin
        any     = 1'b1;
        gnt[j]  = 1'b1;
        gnt_idx = PW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (any) begin
      ptr_q <= (int'(gnt_idx) == N - 1) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/crx_group_table.sv
module crx_group_table
  import crx_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int NGRP  = 16,
  parameter int W     = 16,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_we,
  input  logic [GW-1:0]                    cfg_grp,
  input  logic [NPORT-1:0]                 cfg_mask,
  input  red_op_e                          cfg_op,
  input  logic                             cfg_sgn,
  input  logic                             acc_v,
  input  logic [PW-1:0]                    acc_port,
  input  logic [GW-1:0]                    acc_grp,
  input  logic [W-1:0]                     acc_data,
  input  logic [NPORT-1:0]                 ld,
  input  logic [NPORT-1:0][GW-1:0]         ld_grp,
  output logic [NGRP-1:0][NPORT-1:0]       pend,
  output logic [NGRP-1:0][W-1:0]           res,
  output logic                             err_flag
);
  logic [NPORT-1:0] mem_q [NGRP];
  logic [NPORT-1:0] arr_q [NGRP];
  red_op_e          op_q  [NGRP];
  logic             sgn_q [NGRP];
  logic [W-1:0]     acc_q [NGRP];
  logic [NGRP-1:0][NPORT-1:0] pend_q;
  logic             err_q;

  logic [NPORT-1:0] cur_mem, cur_arr, port_bit, new_arr;
  logic [W-1:0]     cur_acc, alu_y;
  logic             bad, done;

  always_comb begin
    cur_mem  = mem_q[acc_grp];
    cur_arr  = arr_q[acc_grp];
    cur_acc  = acc_q[acc_grp];
    port_bit = '0;
    port_bit[acc_port] = 1'b1;
    bad      = !cur_mem[acc_port] || cur_arr[acc_port];
    new_arr  = cur_arr | port_bit;
    done     = (new_arr == cur_mem);
  end

  crx_alu #(.W(W)) u_alu (
    .op  (op_q[acc_grp]),
    .sgn (sgn_q[acc_grp]),
    .a   (cur_acc),
    .b   (acc_data),
    .y   (alu_y)
  );

  // scratch accumulators: no reset, one write port
  always_ff @(posedge clk) begin
    if (!cfg_we && acc_v && !bad) begin
      acc_q[acc_grp] <= (cur_arr == '0) ? acc_data : alu_y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < NGRP; g++) begin
        mem_q[g] <= '0;
        arr_q[g] <= '0;
        op_q[g]  <= OP_ADD;
        sgn_q[g] <= 1'b0;
      end
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      for (int p = 0; p < NPORT; p++) begin
        if (ld[p]) pend_q[ld_grp[p]][p] <= 1'b0;
      end
      if (cfg_we) begin
        mem_q[cfg_grp] <= cfg_mask;
        arr_q[cfg_grp] <= '0;
        op_q[cfg_grp]  <= cfg_op;
        sgn_q[cfg_grp] <= cfg_sgn;
      end else if (acc_v) begin
        if (bad) begin
          err_q <= 1'b1;
        end else if (done) begin
          arr_q[acc_grp]  <= '0;
          pend_q[acc_grp] <= cur_mem;
        end else begin
          arr_q[acc_grp] <= new_arr;
        end
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_res
    assign res[g] = acc_q[g];
  end

  assign pend     = pend_q;
  assign err_flag = err_q;
endmodule

// File: rtl/crx_fanout.sv
module crx_fanout #(
  parameter int NPORT = 8,
  parameter int NGRP  = 16,
  parameter int W     = 16,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NGRP-1:0][NPORT-1:0]  pend,
  input  logic [NGRP-1:0][W-1:0]      res,
  input  logic [NPORT-1:0]            out_ready,
  output logic [NPORT-1:0]            out_valid,
  output logic [NPORT-1:0][GW-1:0]    out_grp,
  output logic [NPORT-1:0][W-1:0]     out_data,
  output logic [NPORT-1:0]            ld,
  output logic [NPORT-1:0][GW-1:0]    ld_grp
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic          hit;
    logic [GW-1:0] sel;
    logic          ov_q;
    logic [GW-1:0] og_q;
    logic [W-1:0]  od_q;

    always_comb begin
      hit = 1'b0;
      sel = '0;
      for (int g = 0; g < NGRP; g++) begin
        if (!hit && pend[g][p]) begin
          hit = 1'b1;
          sel = GW'(g);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ov_q <= 1'b0;
        og_q <= '0;
        od_q <= '0;
      end else if (!ov_q && hit) begin
        ov_q <= 1'b1;
        og_q <= sel;
        od_q <= res[sel];
      end else if (ov_q && out_ready[p]) begin
        ov_q <= 1'b0;
      end
    end

    assign ld[p]        = !ov_q && hit;
    assign ld_grp[p]    = sel;
    assign out_valid[p] = ov_q;
    assign out_grp[p]   = og_q;
    assign out_data[p]  = od_q;
  end
endmodule

// File: rtl/crx_engine.sv
module crx_engine
  import crx_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int NGRP  = 16,
  parameter int W     = 16,
  localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [GW-1:0]        cfg_grp,
  input  logic [NPORT-1:0]     cfg_mask,
  input  logic [2:0]           cfg_op,
  input  logic                 cfg_sgn,
  input  logic [NPORT-1:0]     in_valid,
  output logic [NPORT-1:0]     in_ready,
  input  logic [NPORT*GW-1:0]  in_grp,
  input  logic [NPORT*W-1:0]   in_data,
  output logic [NPORT-1:0]     out_valid,
  input  logic [NPORT-1:0]     out_ready,
  output logic [NPORT*GW-1:0]  out_grp,
  output logic [NPORT*W-1:0]   out_data,
  output logic                 err_flag
);
  logic [NPORT-1:0][GW-1:0]   in_grp_a, ov_grp, ld_grp;
  logic [NPORT-1:0][W-1:0]    in_data_a, ov_data;
  logic [NGRP-1:0][NPORT-1:0] pend;
  logic [NGRP-1:0][W-1:0]     res;
  logic [NGRP-1:0]            busy;
  logic [NPORT-1:0]           req, gnt, ld, ov;
  logic [PW-1:0]              gnt_idx;
  logic                       acc_v;

  for (genvar p = 0; p < NPORT; p++) begin : g_unpack
    assign in_grp_a[p]          = in_grp[p*GW +: GW];
    assign in_data_a[p]         = in_data[p*W +: W];
    assign out_grp[p*GW +: GW]  = ov_grp[p];
    assign out_data[p*W +: W]   = ov_data[p];
  end

  // a group is busy while its result is still owed to any member
  always_comb begin
    busy = '0;
    for (int g = 0; g < NGRP; g++) begin
      busy[g] = |pend[g];
      for (int p = 0; p < NPORT; p++) begin
        if (ov[p] && ov_grp[p] == GW'(g)) busy[g] = 1'b1;
      end
    end
    for (int p = 0; p < NPORT; p++) begin
      req[p] = in_valid[p] && !cfg_we && !busy[in_grp_a[p]];
    end
  end

  crx_rr_arb #(.N(NPORT)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .gnt     (gnt),
    .gnt_idx (gnt_idx),
    .any     (acc_v)
  );

  crx_group_table #(.NPORT(NPORT), .NGRP(NGRP), .W(W)) u_tbl (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_grp  (cfg_grp),
    .cfg_mask (cfg_mask),
    .cfg_op   (red_op_e'(cfg_op)),
    .cfg_sgn  (cfg_sgn),
    .acc_v    (acc_v),
    .acc_port (gnt_idx),
    .acc_grp  (in_grp_a[gnt_idx]),
    .acc_data (in_data_a[gnt_idx]),
    .ld       (ld),
    .ld_grp   (ld_grp),
    .pend     (pend),
    .res      (res),
    .err_flag (err_flag)
  );

  crx_fanout #(.NPORT(NPORT), .NGRP(NGRP), .W(W)) u_fan (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .res       (res),
    .out_ready (out_ready),
    .out_valid (ov),
    .out_grp   (ov_grp),
    .out_data  (ov_data),
    .ld        (ld),
    .ld_grp    (ld_grp)
  );

  assign in_ready  = gnt;
  assign out_valid = ov;
endmodule

// File: rtl/crx_engine_chk.sv
module crx_engine_chk #(
  parameter int NPORT = 8,
  parameter int W     = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_we,
  input logic [NPORT-1:0]    in_valid,
  input logic [NPORT-1:0]    in_ready,
  input logic [NPORT-1:0]    out_valid,
  input logic [NPORT-1:0]    out_ready,
  input logic [NPORT*W-1:0]  out_data,
  input logic                err_flag
);
  a_r2_cfg_blocks_input: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (in_ready == '0));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_ready));

  a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);

  a_r8_err_after_accept: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> $past(|(in_valid & in_ready)));

  for (genvar p = 0; p < NPORT; p++) begin : g_hold
    a_r9_out_hold: assert property (@(posedge clk) disable iff (rst)
      (out_valid[p] && !out_ready[p]) |=>
        (out_valid[p] && $stable(out_data[p*W +: W])));
  end
endmodule

bind crx_engine crx_engine_chk #(.NPORT(NPORT), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .err_flag  (err_flag)
);

// File: tb/tb_crx_engine.sv
module tb_crx_engine;
  localparam int NP = 4;
  localparam int NG = 4;
  localparam int W  = 8;
  localparam int GW = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [GW-1:0]     cfg_grp = '0;
  logic [NP-1:0]     cfg_mask = '0;
  logic [2:0]        cfg_op = '0;
  logic              cfg_sgn = 1'b0;
  logic [NP-1:0]     in_valid = '0;
  logic [NP-1:0]     in_ready;
  logic [NP*GW-1:0]  in_grp = '0;
  logic [NP*W-1:0]   in_data = '0;
  logic [NP-1:0]     out_valid;
  logic [NP-1:0]     out_ready = '1;
  logic [NP*GW-1:0]  out_grp;
  logic [NP*W-1:0]   out_data;
  logic              err_flag;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int got_cnt [NP];
  logic [W-1:0]  got_val [NP];
  logic [GW-1:0] got_grp [NP];

  crx_engine #(.NPORT(NP), .NGRP(NG), .W(W)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_grp(cfg_grp),
    .cfg_mask(cfg_mask), .cfg_op(cfg_op), .cfg_sgn(cfg_sgn),
    .in_valid(in_valid), .in_ready(in_ready), .in_grp(in_grp),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_grp(out_grp), .out_data(out_data), .err_flag(err_flag)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // result collector: handshakes seen between edges
  always @(negedge clk) begin
    #1;
    for (int p = 0; p < NP; p++) begin
      if (out_valid[p] && out_ready[p]) begin
        got_cnt[p]++;
        got_val[p] = out_data[p*W +: W];
        got_grp[p] = out_grp[p*GW +: GW];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic clr_got();
    for (int p = 0; p < NP; p++) got_cnt[p] = 0;
  endtask

  task automatic cfg(input int g, input logic [NP-1:0] m, input int op, input bit s);
    @(negedge clk);
    cfg_we = 1'b1; cfg_grp = GW'(g); cfg_mask = m; cfg_op = 3'(op); cfg_sgn = s;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int p, input int g, input logic [W-1:0] d);
    @(negedge clk);
    in_valid[p] = 1'b1;
    in_grp[p*GW +: GW] = GW'(g);
    in_data[p*W +: W] = d;
    #1;
    while (!in_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  function automatic logic [W-1:0] ref_op(int op, bit s, logic [W-1:0] a, logic [W-1:0] b);
    bit lt;
    lt = s ? ($signed(a) < $signed(b)) : (a < b);
    case (op)
      0: return a + b;
      1: return lt ? a : b;
      2: return lt ? b : a;
      3: return a & b;
      4: return a | b;
      default: return a ^ b;
    endcase
  endfunction

  initial begin
    int round;
    for (int p = 0; p < NP; p++) begin
      got_cnt[p] = 0; got_val[p] = '0; got_grp[p] = '0;
    end
    void'($urandom(11));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(err_flag == 1'b0, "R1 err_flag in reset", int'(err_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == '0, "R1 in_ready idle", int'(in_ready), 0);
    chk(err_flag == 1'b0, "R1 err_flag after reset", int'(err_flag), 0);

    // R4 R5 R6 R7 R10: sweep operators, formats and member masks
    round = 0;
    for (int op = 0; op < 6; op++) begin
      for (int s = 0; s < 2; s++) begin
        for (int m = 1; m < 16; m++) begin
          int mem [NP];
          int n;
          int g;
          logic [W-1:0] d [NP];
          logic [W-1:0] exp;
          string tag;
          g = round % NG;
          round++;
          cfg(g, NP'(m), op, s[0]);
          clr_got();
          n = 0;
          for (int p = 0; p < NP; p++) if (m[p]) begin mem[n] = p; n++; end
          for (int i = n - 1; i > 0; i--) begin
            int k, t;
            k = $urandom_range(0, i);
            t = mem[i]; mem[i] = mem[k]; mem[k] = t;
          end
          for (int i = 0; i < n; i++) begin
            d[i] = W'($urandom);
            exp = (i == 0) ? d[0] : ref_op(op, s[0], exp, d[i]);
          end
          for (int i = 0; i < n; i++) send(mem[i], g, d[i]);
          chk(out_valid == '0, "R10 not early", int'(out_valid), 0);
          @(negedge clk);
          chk(out_valid == NP'(m), "R10 due", int'(out_valid), m);
          repeat (3) @(negedge clk);
          if (n == 1) tag = "R7";
          else if (op == 1 || op == 2) tag = "R6";
          else tag = "R5";
          for (int p = 0; p < NP; p++) begin
            if (m[p]) begin
              chk(got_cnt[p] == 1 && got_val[p] == exp && got_grp[p] == GW'(g),
                  tag, int'(got_val[p]), int'(exp));
            end else begin
              chk(got_cnt[p] == 0, "R4 non-member", got_cnt[p], 0);
            end
          end
        end
      end
    end

    // R8: duplicate and non-member contributions
    cfg(0, 4'b0011, 0, 1'b0);
    clr_got();
    send(0, 0, 8'd10);
    chk(err_flag == 1'b0, "R8 first ok", int'(err_flag), 0);
    send(0, 0, 8'd20);
    chk(err_flag == 1'b1, "R8 duplicate", int'(err_flag), 1);
    send(3, 0, 8'd5);
    chk(err_flag == 1'b1, "R8 non-member", int'(err_flag), 1);
    send(1, 0, 8'd7);
    repeat (3) @(negedge clk);
    chk(got_cnt[0] == 1 && got_val[0] == 8'd17, "R8 result", int'(got_val[0]), 17);
    chk(got_cnt[1] == 1 && got_val[1] == 8'd17, "R8 result", int'(got_val[1]), 17);
    chk(got_cnt[3] == 0, "R4 dropped sender", got_cnt[3], 0);

    // R2: cfg blocks input and clears arrivals
    cfg(3, 4'b0000, 0, 1'b0);
    cfg(1, 4'b0011, 4, 1'b0);
    send(0, 1, 8'h0F);
    @(negedge clk);
    cfg_we = 1'b1; cfg_grp = 2'd1; cfg_mask = 4'b0011; cfg_op = 3'd5; cfg_sgn = 1'b0;
    in_valid[2] = 1'b1; in_grp[2*GW +: GW] = 2'd3; in_data[2*W +: W] = 8'h00;
    #1;
    chk(in_ready == '0, "R2 blocked during cfg", int'(in_ready), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1;
    chk(in_ready[2] == 1'b1, "R2 accepted after cfg", int'(in_ready), 4);
    @(negedge clk);
    in_valid[2] = 1'b0;
    clr_got();
    send(0, 1, 8'hF0);
    chk(err_flag == 1'b0, "R2 arrivals cleared", int'(err_flag), 0);
    send(1, 1, 8'h33);
    repeat (3) @(negedge clk);
    chk(got_cnt[0] == 1 && got_val[0] == 8'hC3, "R2 new op", int'(got_val[0]), 8'hC3);
    chk(got_cnt[1] == 1 && got_val[1] == 8'hC3, "R2 new op", int'(got_val[1]), 8'hC3);

    // R3: round-robin among three requesters (group 3 has no members)
    begin
      int acc [NP];
      for (int p = 0; p < NP; p++) acc[p] = 0;
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        in_valid[p] = 1'b1; in_grp[p*GW +: GW] = 2'd3;
      end
      for (int c = 0; c < 6; c++) begin
        #1;
        chk($countones(in_ready) == 1, "R3 one grant", $countones(in_ready), 1);
        for (int p = 0; p < NP; p++) if (in_ready[p]) acc[p]++;
        @(negedge clk);
      end
      in_valid = '0;
      for (int p = 0; p < 3; p++) chk(acc[p] == 2, "R3 fairness", acc[p], 2);
      chk(acc[3] == 0, "R3 no grant without valid", acc[3], 0);
    end

    // R9 R11: backpressure on one port stalls only its group
    cfg(0, 4'b0011, 2, 1'b1);
    cfg(2, 4'b0101, 3, 1'b0);
    clr_got();
    out_ready[1] = 1'b0;
    send(0, 0, 8'hFB);
    send(1, 0, 8'h03);
    repeat (2) @(negedge clk);
    chk(out_valid[1] == 1'b1 && out_data[W +: W] == 8'h03, "R9 held", int'(out_data[W +: W]), 3);
    chk(got_cnt[0] == 1 && got_val[0] == 8'h03, "R6 signed max", int'(got_val[0]), 3);
    repeat (4) @(negedge clk);
    chk(out_valid[1] == 1'b1 && out_data[W +: W] == 8'h03, "R9 stable", int'(out_data[W +: W]), 3);
    send(0, 2, 8'hF0);
    send(2, 2, 8'h3C);
    repeat (3) @(negedge clk);
    chk(got_cnt[0] == 2 && got_val[0] == 8'h30, "R11 other group", int'(got_val[0]), 8'h30);
    chk(got_cnt[2] == 1 && got_val[2] == 8'h30, "R11 other group", int'(got_val[2]), 8'h30);
    @(negedge clk);
    in_valid[0] = 1'b1; in_grp[0 +: GW] = 2'd0; in_data[0 +: W] = 8'd9;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(in_ready[0] == 1'b0, "R9 group busy", int'(in_ready[0]), 0);
      @(negedge clk);
    end
    out_ready[1] = 1'b1;
    begin
      bit seen;
      seen = 1'b0;
      for (int c = 0; c < 5; c++) begin
        #1;
        if (in_ready[0]) seen = 1'b1;
        @(negedge clk);
        if (seen) break;
      end
      in_valid[0] = 1'b0;
      chk(seen, "R9 freed after accept", int'(seen), 1);
    end
    chk(got_cnt[1] == 1 && got_val[1] == 8'h03, "R9 delivered once", got_cnt[1], 1);
    clr_got();
    send(1, 0, 8'd2);
    repeat (3) @(negedge clk);
    chk(got_cnt[0] == 1 && got_val[0] == 8'd9, "R9 next step", int'(got_val[0]), 9);
    chk(got_cnt[1] == 1 && got_val[1] == 8'd9, "R9 next step", int'(got_val[1]), 9);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule